// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a line that idles high. It runs directly on a clock at sixteen times the bit rate. The line first passes through a two-flop synchroniser. A low level on the synchronised line starts a frame. The start bit is confirmed near its middle, and every later bit is sampled one bit period after the one before it. A character has 5 to 8 data bits, sent least significant bit first, and may carry a parity bit. It is followed by one or more stop bits. Only the first stop bit is examined.

At the middle of the first stop bit, the received character is written, right-justified, into a holding register. The overrun and parity flags are updated on that same edge. One clock later the data-received flag rises and the framing flag is updated. The receiver then hunts for the next start bit at once, without waiting for the stop bits to end. A host reads the character while data-received is high, then pulses the active-low acknowledge input to drop the flag.

Top module: `ovs_rx_top`

## Requirements
- R1: The serial input reaches the control logic through two flops that reset to 1. The first edge on which the synchronised line is seen low while idle is the detection edge. The start bit is sampled on the 8th clock edge after the detection edge.
- R2: If the line is high at the start-bit sample, the event is discarded. No character is stored, no flag changes, and the receiver returns to idle.
- R3: Data bits are sampled every 16 clocks after the start sample, LSB first. `lenSel` selects the data bit count: 00=5, 01=6, 10=7, 11=8. `rxData[0]` holds the first data bit and unused upper bits are 0. `rxData` changes only on a transfer.
- R4: On each transfer, `overrunErr` takes the value `dataRcvd` had just before that transfer.
- R5: One clock after the transfer, `dataRcvd` goes to 1. On the same edge `frameErr` becomes 1 if the first stop bit was sampled low, and 0 otherwise.
- R6: When `parOff` is 0, one parity bit follows the data. With `parEven`=1 the data bits plus the parity bit must hold an even number of ones; with `parEven`=0 they must hold an odd number. A mismatch sets `parityErr` on the transfer. When `parOff` is 1, no parity bit is expected and `parityErr` is 0.
- R7: `dataRcvdClrN`=0 at a clock edge clears `dataRcvd`. If the flag is being set on that same edge, the set wins.
- R8: The receiver can detect a new start bit two clocks after the first-stop-bit sample. A following frame whose start edge comes 10 clocks into a stop bit is therefore received.
- R9: `masterRst`=1 clears `dataRcvd`, `parityErr`, `frameErr` and `overrunErr` and returns the receiver to idle. It leaves `rxData` unchanged.
- R10: `lenSel`, `parOff` and `parEven` are captured on the detection edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16 times the bit rate |
| masterRst | input | 1 | Asynchronous master reset, active high |
| serialIn | input | 1 | Serial line, idles high |
| lenSel | input | 2 | Character length code |
| parOff | input | 1 | 1 = no parity bit |
| parEven | input | 1 | 1 = even parity, 0 = odd parity |
| dataRcvdClrN | input | 1 | Active-low clear of the data-received flag |
| rxData | output | DW | Received character, right-justified |
| dataRcvd | output | 1 | A character is waiting in `rxData` |
| parityErr | output | 1 | Parity mismatch on the held character |
| frameErr | output | 1 | First stop bit of the held character was low |
| overrunErr | output | 1 | Previous character was not acknowledged before this one arrived |

## Verification
The bench sends short start pulses that must be rejected. A design that samples too early, or does not recheck the start bit, would store a false character. It sends frames whose next start edge falls inside the first stop bit; a receiver that waits for a full stop bit would lose the second character. It also drives a low stop bit, wrong parity in odd mode, unacknowledged characters and a length change in the middle of a frame. Each of these exposes a wrong flag timing, an overrun taken from the wrong value, or a length read late, because the model compares every output on every clock.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_POST
  } rxState_e;

  // strobes and frame settings passed from control to datapath
  typedef struct packed {
    logic       shiftBit;   // sample a data bit
    logic       capParity;  // sample the parity bit
    logic       xfer;       // first stop-bit center: move character to buffer
    logic       setFlags;   // one clock later: data-received and framing
    logic [1:0] lenCode;    // captured length code
    logic       parOn;      // captured parity enable
    logic       parEven;    // captured parity sense
  } rxStrobe_t;

endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ovs_rx_ctrl.sv
module ovs_rx_ctrl
  import ovs_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  input  logic [1:0] lenSel,
  input  logic       parOff,
  input  logic       parEven,
  output rxStrobe_t  strb
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);

  rxState_e      state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bitIdx;
  logic [1:0]    cfgLen;
  logic          cfgPar;
  logic          cfgEven;
  logic          sampleNow;
  logic          lastBit;

  assign sampleNow = (cnt == CNT_LAST);
  assign lastBit   = (bitIdx == IW'(DW - 4) + IW'(cfgLen));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      cfgLen  <= '0;
      cfgPar  <= 1'b0;
      cfgEven <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            state   <= ST_START;
            cnt     <= '0;
            cfgLen  <= lenSel;
            cfgPar  <= !parOff;
            cfgEven <= parEven;
          end
        end
        ST_START: begin
          if (cnt == CNT_MID) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          cnt <= sampleNow ? '0 : cnt + 1'b1;
          if (sampleNow) begin
            bitIdx <= bitIdx + 1'b1;
            if (lastBit) state <= cfgPar ? ST_PARITY : ST_STOP;
          end
        end
        ST_PARITY: begin
          cnt <= sampleNow ? '0 : cnt + 1'b1;
          if (sampleNow) state <= ST_STOP;
        end
        ST_STOP: begin
          cnt <= sampleNow ? '0 : cnt + 1'b1;
          if (sampleNow) state <= ST_POST;
        end
        ST_POST: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.shiftBit  = (state == ST_DATA)   && sampleNow;
    strb.capParity = (state == ST_PARITY) && sampleNow;
    strb.xfer      = (state == ST_STOP)   && sampleNow;
    strb.setFlags  = (state == ST_POST);
    strb.lenCode   = cfgLen;
    strb.parOn     = cfgPar;
    strb.parEven   = cfgEven;
  end

endmodule

// File: rtl/ovs_rx_dp.sv
module ovs_rx_dp
  import ovs_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxLine,
  input  logic          dataRcvdClrN,
  input  rxStrobe_t     strb,
  output logic [DW-1:0] rxData,
  output logic          dataRcvd,
  output logic          parityErr,
  output logic          frameErr,
  output logic          overrunErr
);

  logic [DW-1:0] shiftReg;
  logic [DW-1:0] justified;
  logic [1:0]    shAmt;
  logic          parBit;
  logic          stopBit;
  logic          onesOdd;

  assign shAmt     = 2'd3 - strb.lenCode;
  assign justified = shiftReg >> shAmt;
  assign onesOdd   = ^justified;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftReg   <= '0;
      parBit     <= 1'b0;
      stopBit    <= 1'b1;
      dataRcvd   <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (strb.shiftBit)  shiftReg <= {rxLine, shiftReg[DW-1:1]};
      if (strb.capParity) parBit   <= rxLine;
      if (strb.xfer) begin
        stopBit    <= rxLine;
        overrunErr <= dataRcvd;
        parityErr  <= strb.parOn & (onesOdd ^ parBit ^ ~strb.parEven);
      end
      if (strb.setFlags) begin
        dataRcvd <= 1'b1;
        frameErr <= ~stopBit;
      end else if (!dataRcvdClrN) begin
        dataRcvd <= 1'b0;
      end
    end
  end

  // holding register survives master reset
  always_ff @(posedge clk) begin
    if (strb.xfer) rxData <= justified;
  end

endmodule

// File: rtl/ovs_rx_top.sv
module ovs_rx_top
  import ovs_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          masterRst,
  input  logic          serialIn,
  input  logic [1:0]    lenSel,
  input  logic          parOff,
  input  logic          parEven,
  input  logic          dataRcvdClrN,
  output logic [DW-1:0] rxData,
  output logic          dataRcvd,
  output logic          parityErr,
  output logic          frameErr,
  output logic          overrunErr
);

  logic      rxSync;
  rxStrobe_t strb;

  ovs_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (masterRst),
    .din (serialIn),
    .dout(rxSync)
  );

  ovs_rx_ctrl #(.OVS(OVS), .DW(DW)) ctrl_i (
    .clk    (clk),
    .rst    (masterRst),
    .rxLine (rxSync),
    .lenSel (lenSel),
    .parOff (parOff),
    .parEven(parEven),
    .strb   (strb)
  );

  ovs_rx_dp #(.DW(DW)) dp_i (
    .clk         (clk),
    .rst         (masterRst),
    .rxLine      (rxSync),
    .dataRcvdClrN(dataRcvdClrN),
    .strb        (strb),
    .rxData      (rxData),
    .dataRcvd    (dataRcvd),
    .parityErr   (parityErr),
    .frameErr    (frameErr),
    .overrunErr  (overrunErr)
  );

endmodule

// File: rtl/ovs_rx_chk.sv
module ovs_rx_chk
  import ovs_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          masterRst,
  input logic          dataRcvdClrN,
  input rxStrobe_t     strb,
  input logic [DW-1:0] rxData,
  input logic          dataRcvd,
  input logic          parityErr,
  input logic          frameErr,
  input logic          overrunErr
);

  AST_XFER_THEN_DR: assert property (@(posedge clk) disable iff (masterRst)
    strb.xfer |-> ##2 dataRcvd); // R5

  AST_FE_ON_POST: assert property (@(posedge clk) disable iff (masterRst)
    $rose(frameErr) |-> $past(strb.setFlags)); // R5

  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (masterRst)
    (!dataRcvdClrN && !strb.setFlags) |=> !dataRcvd); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (masterRst)
    !strb.xfer |=> $stable(rxData)); // R3

  AST_OE_ON_XFER: assert property (@(posedge clk) disable iff (masterRst)
    $rose(overrunErr) |-> $past(strb.xfer)); // R4

  AST_PE_INHIBIT: assert property (@(posedge clk) disable iff (masterRst)
    (strb.xfer && !strb.parOn) |=> !parityErr); // R6

endmodule

bind ovs_rx_top ovs_rx_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .masterRst   (masterRst),
  .dataRcvdClrN(dataRcvdClrN),
  .strb        (strb),
  .rxData      (rxData),
  .dataRcvd    (dataRcvd),
  .parityErr   (parityErr),
  .frameErr    (frameErr),
  .overrunErr  (overrunErr)
);

// File: tb/ovs_rx_top_tb_top.sv
module ovs_rx_top_tb_top;

  logic       clk = 1'b0;
  logic       masterRst = 1'b1;
  logic       serialIn = 1'b1;
  logic [1:0] lenSel = 2'b11;
  logic       parOff = 1'b1;
  logic       parEven = 1'b0;
  logic       dataRcvdClrN = 1'b1;
  logic [7:0] rxData;
  logic       dataRcvd, parityErr, frameErr, overrunErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ovs_rx_top dut_i (
    .clk(clk), .masterRst(masterRst), .serialIn(serialIn), .lenSel(lenSel),
    .parOff(parOff), .parEven(parEven), .dataRcvdClrN(dataRcvdClrN),
    .rxData(rxData), .dataRcvd(dataRcvd), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic m1 = 1'b1, m2 = 1'b1, cur;
  int   mPhase = 0;      // 0 idle, 1 in frame
  int   tick = 0, mLen = 8, mSlot = 0, ones = 0;
  bit   mPar, mEven, mParBit, mStop, mPendPost, setNow, mValid = 1'b0;
  logic [7:0] mAcc, mData;
  logic mDR = 0, mPE = 0, mFE = 0, mOE = 0;

  always @(posedge clk) begin
    if (masterRst) begin
      m1 = 1; m2 = 1; mPhase = 0; mPendPost = 0;
      mDR = 0; mPE = 0; mFE = 0; mOE = 0;
    end else begin
      cur = m2; m2 = m1; m1 = serialIn;
      setNow = 0;
      if (mPendPost) begin
        mDR = 1; mFE = !mStop; mPendPost = 0; mPhase = 0; setNow = 1;
      end else if (mPhase == 0) begin
        if (!cur) begin
          mPhase = 1; tick = 0; mLen = 5 + lenSel; mPar = !parOff;
          mEven = parEven; mAcc = 8'h00;
        end
      end else begin
        tick++;
        if (tick == 8) begin
          if (cur) mPhase = 0;
        end else if (tick > 8 && (tick - 8) % 16 == 0) begin
          mSlot = (tick - 8) / 16;
          if (mSlot <= mLen) mAcc[mSlot-1] = cur;
          else if (mPar && mSlot == mLen + 1) mParBit = cur;
          else begin
            mOE = mDR; mData = mAcc; mValid = 1;
            ones = $countones(mAcc) + int'(mParBit);
            mPE = mPar && (mEven ? (ones % 2 == 1) : (ones % 2 == 0));
            mStop = cur; mPendPost = 1; mPhase = 2;
          end
        end
      end
      if (!setNow && !dataRcvdClrN) mDR = 0;
    end
  end

  always @(negedge clk) begin
    if (!masterRst && !finished) begin
      check("R5 dataRcvd", dataRcvd, mDR);
      check("R5 frameErr", frameErr, mFE);
      check("R6 parityErr", parityErr, mPE);
      check("R4 overrunErr", overrunErr, mOE);
      if (mValid) check("R3 rxData", rxData, mData);
    end
  end

  // ---------------- stimulus ----------------
  task automatic holdBit(input logic b, input int n);
    serialIn = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit withPar,
                           input bit even, input bit flipPar, input logic stopLvl,
                           input int stopClks);
    int cnt1 = 0;
    holdBit(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      cnt1 += int'(d[i]);
      holdBit(d[i], 16);
    end
    if (withPar) holdBit(logic'((even ? (cnt1 % 2) : 1 - (cnt1 % 2)) ^ int'(flipPar)), 16);
    holdBit(stopLvl, stopClks);
    serialIn = 1'b1;
  endtask

  task automatic clearDr();
    dataRcvdClrN = 1'b0;
    @(negedge clk);
    dataRcvdClrN = 1'b1;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    masterRst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 dataRcvd after reset", dataRcvd, 0);
    check("R9 flags after reset", {parityErr, frameErr, overrunErr}, 0);
    holdBit(1'b1, 20);

    // R1 R3 R6: 8 bits, even parity, correct
    lenSel = 2'b11; parOff = 0; parEven = 1;
    sendFrame(8'hA5, 8, 1, 1, 0, 1'b1, 16);
    holdBit(1'b1, 8);
    check("R1 R3 char 8 bit", rxData, 8'hA5);
    check("R5 dataRcvd set", dataRcvd, 1);
    check("R6 even parity ok", parityErr, 0);
    check("R4 no overrun", overrunErr, 0);

    // R4 R3 R6: 5 bits, parity off, flag not acknowledged
    lenSel = 2'b00; parOff = 1;
    sendFrame(8'hF3, 5, 0, 0, 0, 1'b1, 16);
    holdBit(1'b1, 8);
    check("R3 5 bit right justified", rxData, 8'h13);
    check("R4 overrun set", overrunErr, 1);
    check("R6 parity inhibited", parityErr, 0);

    // R7 acknowledge
    clearDr();
    @(negedge clk);
    check("R7 dataRcvd cleared", dataRcvd, 0);

    // R6 odd parity wrong, 7 bits
    lenSel = 2'b10; parOff = 0; parEven = 0;
    sendFrame(8'h5A, 7, 1, 0, 1, 1'b1, 16);
    holdBit(1'b1, 8);
    check("R3 7 bit char", rxData, 8'h5A);
    check("R6 odd parity error", parityErr, 1);
    check("R4 overrun clear after ack", overrunErr, 0);
    clearDr();

    // R5 low stop bit, 6 bits
    lenSel = 2'b01; parOff = 1;
    sendFrame(8'h2C, 6, 0, 0, 0, 1'b0, 16);
    holdBit(1'b1, 40);
    check("R5 framing error", frameErr, 1);
    check("R3 6 bit char", rxData, 8'h2C);
    clearDr();
    @(negedge clk);

    // R2 short start pulses rejected
    holdBit(1'b0, 4);
    holdBit(1'b1, 40);
    holdBit(1'b0, 7);
    holdBit(1'b1, 40);
    check("R2 glitch no character", dataRcvd, 0);
    check("R2 glitch data kept", rxData, 8'h2C);

    // R8 next start 10 clocks into the first stop bit
    lenSel = 2'b11; parOff = 1;
    sendFrame(8'h81, 8, 0, 0, 0, 1'b1, 10);
    sendFrame(8'h7E, 8, 0, 0, 0, 1'b1, 16);
    holdBit(1'b1, 8);
    check("R8 back to back second char", rxData, 8'h7E);
    check("R8 second char overrun", overrunErr, 1);
    check("R5 stop high no framing", frameErr, 0);
    clearDr();

    // R10 length changed in mid frame is ignored
    lenSel = 2'b11;
    fork
      sendFrame(8'hC9, 8, 0, 0, 0, 1'b1, 16);
      begin
        repeat (40) @(negedge clk);
        lenSel = 2'b00; parOff = 0;
      end
    join
    holdBit(1'b1, 8);
    check("R10 settings captured at start", rxData, 8'hC9);
    check("R10 parity setting ignored", parityErr, 0);

    // R9 master reset keeps the buffer
    masterRst = 1'b1;
    @(negedge clk);
    masterRst = 1'b0;
    @(negedge clk);
    check("R9 flags cleared", {dataRcvd, parityErr, frameErr, overrunErr}, 0);
    check("R9 data kept", rxData, 8'hC9);
    holdBit(1'b1, 10);
    finishRun();
  end

endmodule